// File: doc/BRIEF.md
# Programmable Pixel Color Matrix

This block applies a run-time programmable 3x3 linear transform to a stream of three-component pixels, one pixel per clock. Each of the three output components is a weighted sum of the three input components plus its own offset. The result is rounded, truncated to the output width and clamped. Typical uses are 8-bit R'G'B' to 10-bit Y'CbCr, or 10-bit Y'CbCr to 8-bit R'G'B'. The input and output widths are separate parameters. The weights are loaded from outside, so one piece of hardware serves any conversion standard, including standard-definition to high-definition re-encoding.

Software or a sequencer writes weights, offsets and a rounding constant through a plain address/data write port. The writes land in a staging bank. The staging bank is copied into the working bank only when a pixel arrives flagged as the first pixel of a frame. Because of this, no frame is ever processed with a mixture of old and new settings. The datapath is three register stages deep: products, then the sum with offset and rounding, then the clamp.

Top module: `csc_matrix`

## Requirements
- R1: Each output k equals M[k][0]*in_c0 + M[k][1]*in_c1 + M[k][2]*in_c2 + OFS[k], with an independent weight row and offset for each output.
- R2: Weights are signed two's complement 16-bit values with 2 integer and 14 fractional bits (16384 = 1.0). The weight M[k][j] is written at address 3*k + j (addresses 0 to 8).
- R3: Offsets are signed 16-bit integers in output code units, written at addresses 9, 10 and 11 for outputs 0, 1 and 2.
- R4: A 16-bit unsigned rounding constant in units of 2^-14, written at address 12, is added to the full-precision sum. The sum is then floored to an integer (arithmetic shift right by 14).
- R5: A result below zero is output as 0.
- R6: A result above 2^OUT_W - 1 is output as 2^OUT_W - 1 (all ones). A result of exactly 2^OUT_W - 1 passes unchanged.
- R7: A pixel presented with in_valid high in cycle t appears on the outputs with out_valid high in cycle t+3. Pixels in consecutive cycles stream out in consecutive cycles.
- R8: Register writes go to a staging bank. The working bank takes the staging contents only when sof and in_valid are both high, and that pixel already uses the new settings. A write in that same cycle waits for the next frame. sof without in_valid has no effect.
- R9: Synchronous active-high reset clears out_valid, the outputs and both banks, so a pixel processed after reset, before any frame start, produces 0 on every output.
- R10: While out_valid is low, the output components hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0-8 weights, 9-11 offsets, 12 rounding) |
| cfg_data | input | 16 | Register write data |
| sof | input | 1 | First pixel of a frame; commits staged settings |
| in_valid | input | 1 | Input pixel valid |
| in_c0 | input | IN_W | Input component 0 |
| in_c1 | input | IN_W | Input component 1 |
| in_c2 | input | IN_W | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_c0 | output | OUT_W | Output component 0 |
| out_c1 | output | OUT_W | Output component 1 |
| out_c2 | output | OUT_W | Output component 2 |

## Verification
The bench targets the rounding edge. A weight of one half applied to a code of one gives 1 with a half-step rounding constant and 0 without one. A design that rounds after truncation, or ignores the constant, reports 1 in both cases or 0 in both. It drives sums below zero, exactly at full scale and just above full scale. A missing or off-by-one clamp would wrap negative results into large codes, or cut the full-scale code. It also writes the bank in the same cycle as a frame start, writes it mid-frame, and pulses sof without a pixel. A design that commits on the wrong condition lets pixels mid-frame use half-loaded settings. Back-to-back streaming and single-pixel probes one cycle early and one cycle late catch a pipeline one stage too short or too long.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int N_CH     = 3;
    localparam int COEF_W   = 16;
    localparam int FRAC_W   = 14;
    localparam int ADDR_W   = 4;
    localparam int N_COEF   = N_CH * N_CH;
    localparam int OFF_BASE = N_COEF;
    localparam int RND_ADDR = OFF_BASE + N_CH;

    typedef logic signed [COEF_W-1:0] coef_t;

    typedef struct packed {
        coef_t [N_CH-1:0][N_CH-1:0] mat;   // mat[out][in]
        coef_t [N_CH-1:0]           off;   // integer output codes
        logic  [COEF_W-1:0]         rnd;   // units of 2^-FRAC_W
    } cset_t;

    typedef enum logic [1:0] {
        FLD_MAT  = 2'd0,
        FLD_OFF  = 2'd1,
        FLD_RND  = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;

    function automatic fld_e decode_fld(input logic [ADDR_W-1:0] a);
        if (int'(a) < OFF_BASE)      return FLD_MAT;
        else if (int'(a) < RND_ADDR) return FLD_OFF;
        else if (int'(a) == RND_ADDR) return FLD_RND;
        else                          return FLD_NONE;
    endfunction

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    input  logic              commit,
    output cset_t             use_set
);

    cset_t stage_q;
    cset_t live_q;
    fld_e  fld;

    assign fld = decode_fld(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (wr_en) begin
            for (int r = 0; r < N_CH; r++) begin
                for (int c = 0; c < N_CH; c++) begin
                    if (fld == FLD_MAT && int'(wr_addr) == r * N_CH + c)
                        stage_q.mat[r][c] <= wr_data;
                end
                if (fld == FLD_OFF && int'(wr_addr) == OFF_BASE + r)
                    stage_q.off[r] <= wr_data;
            end
            if (fld == FLD_RND)
                stage_q.rnd <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            live_q <= '0;
        else if (commit)
            live_q <= stage_q;
    end

    // The committing pixel already sees the staged set.
    assign use_set = commit ? stage_q : live_q;

endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 10
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en_out,
    input  logic [N_CH-1:0][IN_W-1:0]      pix,
    input  coef_t [N_CH-1:0]               k,
    input  coef_t                          off,
    input  logic  [COEF_W-1:0]             rnd,
    output logic  [OUT_W-1:0]              q
);

    localparam int PROD_W = IN_W + 1 + COEF_W;
    localparam int OFS_W  = COEF_W + FRAC_W;
    localparam int ACC_W  = ((PROD_W > OFS_W) ? PROD_W : OFS_W) + 3;
    localparam int RES_W  = ACC_W - FRAC_W;

    // Stage 1: products
    logic signed [PROD_W-1:0] prod_c [N_CH];
    logic signed [PROD_W-1:0] prod_q [N_CH];
    coef_t                    off_q;
    logic [COEF_W-1:0]        rnd_q;

    always_comb begin
        for (int i = 0; i < N_CH; i++)
            prod_c[i] = PROD_W'($signed({1'b0, pix[i]})) * PROD_W'($signed(k[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) prod_q[i] <= '0;
            off_q <= '0;
            rnd_q <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) prod_q[i] <= prod_c[i];
            off_q <= off;
            rnd_q <= rnd;
        end
    end

    // Stage 2: sum, offset and rounding
    logic signed [ACC_W-1:0] sum_c;
    logic signed [ACC_W-1:0] acc_q;

    always_comb begin
        sum_c = ACC_W'($signed(off_q)) <<< FRAC_W;
        sum_c = sum_c + $signed({{(ACC_W-COEF_W){1'b0}}, rnd_q});
        for (int i = 0; i < N_CH; i++)
            sum_c = sum_c + ACC_W'(prod_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= sum_c;
    end

    // Stage 3: floor, clamp, register
    logic signed [RES_W-1:0] res_c;
    logic [OUT_W-1:0]        sat_c;

    always_comb begin
        res_c = RES_W'(acc_q >>> FRAC_W);
        if (res_c[RES_W-1])
            sat_c = '0;
        else if (res_c[RES_W-2:OUT_W] != '0)
            sat_c = '1;
        else
            sat_c = res_c[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (en_out) q <= sat_c;
    end

endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
    import csc_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [15:0]       cfg_data,
    input  logic              sof,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_c0,
    input  logic [IN_W-1:0]   in_c1,
    input  logic [IN_W-1:0]   in_c2,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_c0,
    output logic [OUT_W-1:0]  out_c1,
    output logic [OUT_W-1:0]  out_c2
);

    localparam int LAT = 3;

    cset_t                   cur_set;
    logic                    commit;
    logic [N_CH-1:0][IN_W-1:0]  pix;
    logic [N_CH-1:0][OUT_W-1:0] res;
    logic [LAT-1:0]          vld_q;

    assign commit = sof & in_valid;
    assign pix    = {in_c2, in_c1, in_c0};

    csc_coef_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .commit  (commit),
        .use_set (cur_set)
    );

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[LAT-2:0], in_valid};
    end

    generate
        for (genvar r = 0; r < N_CH; r++) begin : g_row
            csc_row #(.IN_W(IN_W), .OUT_W(OUT_W)) u_row (
                .clk    (clk),
                .rst    (rst),
                .en_out (vld_q[LAT-2]),
                .pix    (pix),
                .k      (cur_set.mat[r]),
                .off    (cur_set.off[r]),
                .rnd    (cur_set.rnd),
                .q      (res[r])
            );
        end
    endgenerate

    assign out_valid = vld_q[LAT-1];
    assign out_c0    = res[0];
    assign out_c1    = res[1];
    assign out_c2    = res[2];

endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [3:0]        cfg_addr,
    input logic [15:0]       cfg_data,
    input logic              sof,
    input logic              in_valid,
    input logic [IN_W-1:0]   in_c0,
    input logic [IN_W-1:0]   in_c1,
    input logic [IN_W-1:0]   in_c2,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_c0,
    input logic [OUT_W-1:0]  out_c1,
    input logic [OUT_W-1:0]  out_c2
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R7: valid emerges exactly three cycles after it entered
    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R10: components frozen while no pixel is presented
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0 && !out_valid) |->
            ($stable(out_c0) && $stable(out_c1) && $stable(out_c2)));

    // R9: reset empties the output side
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_c0 == '0 && out_c1 == '0 && out_c2 == '0));

    // R1: a valid output carries a defined value
    assert_known_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown({out_c0, out_c1, out_c2}));

endmodule

bind csc_matrix csc_matrix_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/csc_matrix_tb.sv
`timescale 1ns/1ps
module csc_matrix_tb_top;

    localparam int IN_W  = 8;
    localparam int OUT_W = 10;
    localparam int MAXC  = (1 << OUT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic [3:0]       cfg_addr = '0;
    logic [15:0]      cfg_data = '0;
    logic             sof = 1'b0;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_c0, out_c1, out_c2;

    int total = 0;
    int bad   = 0;

    // staged and working copies kept by the bench
    int sm[9], so[3], sr;
    int am[9], ao[3], ar;

    always #10 clk = ~clk;

    csc_matrix #(.IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .sof(sof), .in_valid(in_valid),
        .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
        .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model(input int r, input int a, input int b, input int c);
        longint acc;
        longint q;
        acc = longint'(am[3*r]) * a + longint'(am[3*r+1]) * b + longint'(am[3*r+2]) * c
            + (longint'(ao[r]) <<< 14) + longint'(ar);
        q = acc >>> 14;
        if (q < 0) return 0;
        if (q > MAXC) return MAXC;
        return int'(q);
    endfunction

    function automatic int outk(input int r);
        return (r == 0) ? int'(out_c0) : (r == 1) ? int'(out_c1) : int'(out_c2);
    endfunction

    task automatic write_reg(input int addr, input int val);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_data = 16'(val);
        if (addr < 9) sm[addr] = val;
        else if (addr < 12) so[addr-9] = val;
        else if (addr == 12) sr = val & 16'hFFFF;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_set(input int m[9], input int o[3], input int rnd);
        for (int i = 0; i < 9; i++) write_reg(i, m[i]);
        for (int i = 0; i < 3; i++) write_reg(9 + i, o[i]);
        write_reg(12, rnd);
    endtask

    task automatic commit_model();
        am = sm; ao = so; ar = sr;
    endtask

    // one isolated pixel; probes one cycle early and one cycle late
    task automatic send_one(input int a, input int b, input int c, input bit s,
                            input string req);
        int e[3];
        in_c0 = IN_W'(a); in_c1 = IN_W'(b); in_c2 = IN_W'(c);
        in_valid = 1'b1; sof = s;
        if (s) commit_model();
        for (int r = 0; r < 3; r++) e[r] = model(r, a, b, c);
        @(negedge clk);
        in_valid = 1'b0; sof = 1'b0;
        in_c0 = ~in_c0; in_c1 = ~in_c1; in_c2 = ~in_c2;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "valid early", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7", "valid at 3", int'(out_valid), 1);
        for (int r = 0; r < 3; r++)
            chk(outk(r) == e[r], req, $sformatf("out%0d", r), outk(r), e[r]);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "valid late", int'(out_valid), 0);
        for (int r = 0; r < 3; r++)
            chk(outk(r) == e[r], "R10", $sformatf("hold out%0d", r), outk(r), e[r]);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R9", "reset valid", int'(out_valid), 0);
        chk(out_c0 == '0 && out_c1 == '0 && out_c2 == '0, "R9", "reset out",
            int'(out_c0) + int'(out_c1) + int'(out_c2), 0);
        send_one(200, 100, 50, 1'b0, "R9");
    endtask

    task automatic t_identity();
        int m[9] = '{16384, 0, 0, 0, 16384, 0, 0, 0, 16384};
        int o[3] = '{0, 0, 0};
        load_set(m, o, 8192);
        send_one(0, 0, 0, 1'b1, "R2");
        send_one(255, 17, 3, 1'b0, "R2");
        send_one(128, 200, 1, 1'b0, "R2");
    endtask

    // back-to-back stream with a full matrix and offsets
    task automatic t_stream();
        int m[9] = '{4096, 8192, 2048, -4096, -8192, 12288, 12288, -8192, -4096};
        int o[3] = '{64, 512, 512};
        int px[6][3] = '{'{255,0,0}, '{0,255,0}, '{0,0,255},
                         '{10,20,30}, '{255,255,255}, '{77,140,3}};
        int ex[6][3];
        load_set(m, o, 8192);
        for (int i = 0; i < 9; i++) begin
            if (i >= 3) begin
                chk(out_valid == 1'b1, "R7", "stream valid", int'(out_valid), 1);
                for (int r = 0; r < 3; r++)
                    chk(outk(r) == ex[i-3][r], (r == 0) ? "R1" : "R3",
                        $sformatf("stream px%0d out%0d", i - 3, r), outk(r), ex[i-3][r]);
            end
            if (i < 6) begin
                in_c0 = IN_W'(px[i][0]); in_c1 = IN_W'(px[i][1]); in_c2 = IN_W'(px[i][2]);
                in_valid = 1'b1; sof = (i == 0);
                if (i == 0) commit_model();
                for (int r = 0; r < 3; r++) ex[i][r] = model(r, px[i][0], px[i][1], px[i][2]);
            end else begin
                in_valid = 1'b0; sof = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_clamp();
        int m[9] = '{-16384, 0, 0, 32767, 32767, 32767, 0, 0, 0};
        int o[3] = '{0, 0, 1023};
        load_set(m, o, 0);
        send_one(200, 255, 255, 1'b1, "R5");
        chk(out_c0 == '0, "R5", "negative to zero", int'(out_c0), 0);
        chk(out_c1 == 10'(MAXC), "R6", "overflow to max", int'(out_c1), MAXC);
        chk(out_c2 == 10'(MAXC), "R6", "exact max kept", int'(out_c2), MAXC);
        write_reg(11, 1024);
        write_reg(9, -1);
        write_reg(0, 0);
        send_one(0, 0, 0, 1'b1, "R6");
        chk(out_c2 == 10'(MAXC), "R6", "max plus one", int'(out_c2), MAXC);
        chk(out_c0 == '0, "R5", "minus one", int'(out_c0), 0);
    endtask

    task automatic t_round();
        int m[9] = '{8192, 0, 0, -8192, 0, 0, 8191, 0, 0};
        int o[3] = '{0, 1, 0};
        load_set(m, o, 8192);
        send_one(1, 0, 0, 1'b1, "R4");
        chk(out_c0 == 10'd1, "R4", "half rounds up", int'(out_c0), 1);
        chk(out_c2 == 10'd0, "R4", "below half", int'(out_c2), 0);
        write_reg(12, 0);
        send_one(1, 0, 0, 1'b1, "R4");
        chk(out_c0 == 10'd0, "R4", "no round floors", int'(out_c0), 0);
        chk(out_c1 == 10'd0, "R4", "floor of half", int'(out_c1), 0);
    endtask

    task automatic t_commit();
        int m[9] = '{16384, 0, 0, 0, 16384, 0, 0, 0, 16384};
        int o[3] = '{0, 0, 0};
        load_set(m, o, 0);
        send_one(40, 50, 60, 1'b1, "R8");
        // mid-frame write must not apply
        write_reg(9, 100);
        send_one(40, 50, 60, 1'b0, "R8");
        chk(out_c0 == 10'd40, "R8", "mid-frame write ignored", int'(out_c0), 40);
        // sof without a pixel must not commit
        sof = 1'b1; @(negedge clk); sof = 1'b0;
        send_one(40, 50, 60, 1'b0, "R8");
        chk(out_c0 == 10'd40, "R8", "bare sof ignored", int'(out_c0), 40);
        // write together with the committing pixel waits a frame
        cfg_we = 1'b1; cfg_addr = 4'd9; cfg_data = 16'd300;
        in_c0 = 8'd40; in_c1 = 8'd50; in_c2 = 8'd60; in_valid = 1'b1; sof = 1'b1;
        commit_model();
        so[0] = 300;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0; sof = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(out_c0 == 10'd140, "R8", "commit uses staged", int'(out_c0), 140);
        @(negedge clk);
        send_one(40, 50, 60, 1'b1, "R8");
        chk(out_c0 == 10'd340, "R8", "same-cycle write next frame", int'(out_c0), 340);
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 9; i++) begin sm[i] = 0; am[i] = 0; end
        for (int i = 0; i < 3; i++) begin so[i] = 0; ao[i] = 0; end
        sr = 0; ar = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_identity();
        t_stream();
        t_clamp();
        t_round();
        t_commit();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule